// File: doc/BRIEF.md
# SPI Master Burst Transfer Engine

This block is an SPI master that moves whole bytes in counted bursts under software control. Software programs a burst length and a transmit length, writes outgoing bytes into a transmit FIFO, and sets a self-clearing exchange bit. The engine then shifts one byte after another on MOSI, MSB first, and stores every byte captured on MISO in a receive FIFO. The exchange bit reads back as 0 once the last byte of the burst sits in the receive FIFO. Software polls the receive fill level and then reads the bytes out.

Clock polarity and phase are programmable. One of four chip-select outputs is chosen, with either polarity. In automatic mode the chosen select is active while a burst runs. In manual mode it follows a level bit that software owns, so one select can stay asserted across several bursts. The SCLK rate is set outside the block: every pulse on `sclk_tick` moves SCLK by one half period.

The register port accepts one access per cycle and never applies back-pressure. A write to the transmit data address while the transmit FIFO is full is dropped. A read strobe on the receive data address while the receive FIFO is empty returns 0 and changes nothing. A captured byte that finds the receive FIFO full is dropped. Reads are combinational on `reg_addr`. Writes and receive-FIFO pops take effect at the clock edge.

Top module: `spi_burst_master`

Register map (word address on `reg_addr`): 0 global control (bit 0 enable, bit 1 master, bit 31 soft reset); 1 transfer control; 2 FIFO control; 3 FIFO status; 4 burst length; 5 transmit length; 6 transmit data (write pushes a byte); 7 receive data (read strobe pops a byte).

## Requirements
- R1: After reset, the global control, transfer control and FIFO status registers read 0, every `cs_o` pin is 0 and `sclk_o` is 0.
- R2: Writing transfer control bit 31 as 1 sets the exchange bit only while global control bits 0 (enable) and 1 (master) are both 1. Otherwise the write leaves the bit at 0 and no byte is exchanged. Once set, the bit reads 1 until the last byte of the burst has been stored in the receive FIFO, and then it reads 0.
- R3: Each burst moves exactly the programmed burst-length number of bytes, MSB first. A byte presented on MISO is the byte later read back from the receive FIFO.
- R4: Transfer control bit 1 (CPOL) sets the idle level of `sclk_o`. With bit 0 (CPHA) at 0, data is sampled on the leading SCLK edge and changed on the trailing edge. With CPHA at 1, data is changed on the leading edge and sampled on the trailing edge.
- R5: In automatic mode (transfer control bit 6 = 0), the pin chosen by transfer control bits [5:4] is active only while a burst runs, and every other pin stays inactive. Bit 2 = 1 makes the active level 0; otherwise the active level is 1.
- R6: In manual mode (bit 6 = 1), the chosen pin takes the value of transfer control bit 7 and keeps it across bursts. All other pins stay inactive.
- R7: Only the first transmit-length bytes of a burst are taken from the transmit FIFO. Later bytes are sent as 0x00 and leave the FIFO untouched. A byte that is due but finds the transmit FIFO empty is also sent as 0x00.
- R8: FIFO status bits [7:0] give the number of bytes in the receive FIFO. Each read strobe on the receive data address returns the oldest byte and lowers that count by one.
- R9: Writing FIFO control bit 15 empties the receive FIFO, and writing bit 31 empties the transmit FIFO. Both bits clear themselves and read back as 0.
- R10: Writing global control bit 31 aborts any running burst, clears the exchange bit and empties both FIFOs. The bit clears itself, while enable and master keep their written values.
- R11: An exchange started with a burst length of 0 clears the exchange bit on the next cycle without toggling SCLK or storing a byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe (pops the receive FIFO at address 7) |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational on reg_addr |
| sclk_tick | input | 1 | Half-period pulse for SCLK |
| sclk_o | output | 1 | SPI clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| cs_o | output | 4 | Chip-select outputs |

## Verification
A register write takes effect at the next clock edge. Because of this, the exchange bit, the FIFO reset results and the soft-reset results can be read one cycle after the write, and the bench reads them on the cycle after the write completes. The duration of a burst depends on when ticks arrive: each byte needs one load cycle, sixteen ticks and one store cycle. For that reason the bench does not count cycles for a burst; it polls the exchange bit until it reads 0, and only then checks the receive FIFO. All outputs are sampled on the falling clock edge. A serial monitor records MOSI at the sampling edge that each mode defines, and MOSI is looped back to MISO so that received bytes can be compared with transmitted ones.

// File: rtl/spi_burst_pkg.sv
package spi_burst_pkg;

  typedef enum logic [1:0] {
    ENG_IDLE,
    ENG_LOAD,
    ENG_SHIFT,
    ENG_STORE
  } eng_state_e;

  localparam logic [2:0] A_GLOBAL   = 3'd0;
  localparam logic [2:0] A_XFER     = 3'd1;
  localparam logic [2:0] A_FIFOCTL  = 3'd2;
  localparam logic [2:0] A_FIFOSTAT = 3'd3;
  localparam logic [2:0] A_BURST    = 3'd4;
  localparam logic [2:0] A_XMIT     = 3'd5;
  localparam logic [2:0] A_TXDATA   = 3'd6;
  localparam logic [2:0] A_RXDATA   = 3'd7;

  localparam int GC_EN     = 0;
  localparam int GC_MST    = 1;
  localparam int GC_SRST   = 31;
  localparam int XC_CPHA   = 0;
  localparam int XC_CPOL   = 1;
  localparam int XC_ACTLOW = 2;
  localparam int XC_SEL_LO = 4;
  localparam int XC_MANUAL = 6;
  localparam int XC_LEVEL  = 7;
  localparam int XC_START  = 31;
  localparam int FC_RXRST  = 15;
  localparam int FC_TXRST  = 31;

endpackage

// File: rtl/spi_byte_fifo.sv
module spi_byte_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push,
  input  logic [DW-1:0] wdata,
  input  logic          pop,
  output logic [DW-1:0] rdata,
  output logic [CW-1:0] count,
  output logic          empty,
  output logic          full
);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic          do_push, do_pop;

  assign empty   = (count == '0);
  assign full    = (count == CW'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign rdata   = empty ? '0 : mem[rptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else if (clr) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (do_push) wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + AW'(1);
      if (do_pop)  rptr <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + AW'(1);
      case ({do_push, do_pop})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end

endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine
  import spi_burst_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             start,
  input  logic [CNT_W-1:0] burst_len,
  input  logic [CNT_W-1:0] xmit_len,
  input  logic             cpol,
  input  logic             cpha,
  input  logic             tick,
  input  logic             miso,
  input  logic             tx_empty,
  input  logic [7:0]       tx_byte,
  output logic             tx_pop,
  output logic             rx_push,
  output logic [7:0]       rx_byte,
  output logic             sclk,
  output logic             mosi,
  output logic             busy,
  output logic             done
);

  eng_state_e       state;
  logic [CNT_W-1:0] idx;
  logic [7:0]       tx_sh, rx_sh;
  logic [3:0]       hc;
  logic             phase;
  logic             last, want_tx, lead;

  assign last    = (idx == burst_len - CNT_W'(1));
  assign want_tx = (idx < xmit_len);
  assign lead    = !phase;
  assign tx_pop  = (state == ENG_LOAD) && want_tx && !tx_empty;
  assign rx_push = (state == ENG_STORE);
  assign rx_byte = rx_sh;
  assign sclk    = cpol ^ phase;
  assign mosi    = tx_sh[7];
  assign busy    = (state != ENG_IDLE);
  assign done    = ((state == ENG_IDLE) && start && (burst_len == '0)) ||
                   ((state == ENG_STORE) && last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ENG_IDLE;
      idx   <= '0;
      tx_sh <= '0;
      rx_sh <= '0;
      hc    <= '0;
      phase <= 1'b0;
    end else if (clr) begin
      state <= ENG_IDLE;
      idx   <= '0;
      hc    <= '0;
      phase <= 1'b0;
    end else begin
      unique case (state)
        ENG_IDLE: begin
          if (start && burst_len != '0) begin
            idx   <= '0;
            state <= ENG_LOAD;
          end
        end
        ENG_LOAD: begin
          tx_sh <= (want_tx && !tx_empty) ? tx_byte : 8'h00;
          rx_sh <= '0;
          hc    <= '0;
          phase <= 1'b0;
          state <= ENG_SHIFT;
        end
        ENG_SHIFT: begin
          if (tick) begin
            phase <= ~phase;
            hc    <= hc + 4'd1;
            if (lead) begin
              if (!cpha)         rx_sh <= {rx_sh[6:0], miso};
              else if (hc != 0)  tx_sh <= {tx_sh[6:0], 1'b0};
            end else begin
              if (!cpha)         tx_sh <= {tx_sh[6:0], 1'b0};
              else               rx_sh <= {rx_sh[6:0], miso};
            end
            if (hc == 4'd15) state <= ENG_STORE;
          end
        end
        ENG_STORE: begin
          if (last) begin
            state <= ENG_IDLE;
          end else begin
            idx   <= idx + CNT_W'(1);
            state <= ENG_LOAD;
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/spi_cs_ctrl.sv
module spi_cs_ctrl #(
  parameter int NUM_CS = 4,
  localparam int SELW  = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic [SELW-1:0]   sel,
  input  logic              act_low,
  input  logic              manual,
  input  logic              man_level,
  input  logic              busy,
  output logic [NUM_CS-1:0] cs
);

  logic active_lvl, idle_lvl, chosen_lvl;

  assign active_lvl = ~act_low;
  assign idle_lvl   = act_low;
  assign chosen_lvl = manual ? man_level : (busy ? active_lvl : idle_lvl);

  for (genvar i = 0; i < NUM_CS; i++) begin : g_pin
    assign cs[i] = (sel == SELW'(i)) ? chosen_lvl : idle_lvl;
  end

endmodule

// File: rtl/spi_burst_master.sv
module spi_burst_master
  import spi_burst_pkg::*;
#(
  parameter int FIFO_DEPTH = 64,
  parameter int NUM_CS     = 4,
  parameter int CNT_W      = 24,
  localparam int SELW      = (NUM_CS > 1) ? $clog2(NUM_CS) : 1,
  localparam int CW        = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic              reg_re,
  input  logic [2:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              sclk_tick,
  output logic              sclk_o,
  output logic              mosi_o,
  input  logic              miso_i,
  output logic [NUM_CS-1:0] cs_o
);

  logic             glb_en, glb_mst, srst_q;
  logic [7:0]       cfg_q;
  logic             xch_q;
  logic [CNT_W-1:0] burst_q, xmit_q;
  logic             rx_rst_q, tx_rst_q;

  logic             eng_busy, eng_done, tx_pop, rx_push;
  logic [7:0]       rx_wbyte, tx_head, rx_head;
  logic [CW-1:0]    rx_count, tx_count;
  logic             tx_empty, tx_full, rx_empty, rx_full;
  logic             wr_glb, wr_xfer, wr_fifo;

  assign wr_glb  = reg_we && (reg_addr == A_GLOBAL);
  assign wr_xfer = reg_we && (reg_addr == A_XFER);
  assign wr_fifo = reg_we && (reg_addr == A_FIFOCTL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      glb_en   <= 1'b0;
      glb_mst  <= 1'b0;
      srst_q   <= 1'b0;
      cfg_q    <= '0;
      xch_q    <= 1'b0;
      burst_q  <= '0;
      xmit_q   <= '0;
      rx_rst_q <= 1'b0;
      tx_rst_q <= 1'b0;
    end else begin
      srst_q   <= wr_glb && reg_wdata[GC_SRST];
      rx_rst_q <= wr_fifo && reg_wdata[FC_RXRST];
      tx_rst_q <= wr_fifo && reg_wdata[FC_TXRST];
      if (wr_glb) begin
        glb_en  <= reg_wdata[GC_EN];
        glb_mst <= reg_wdata[GC_MST];
      end
      if (wr_xfer) cfg_q <= reg_wdata[7:0];
      if (reg_we && reg_addr == A_BURST) burst_q <= reg_wdata[CNT_W-1:0];
      if (reg_we && reg_addr == A_XMIT)  xmit_q  <= reg_wdata[CNT_W-1:0];
      if (srst_q || eng_done)
        xch_q <= 1'b0;
      else if (wr_xfer && reg_wdata[XC_START] && glb_en && glb_mst)
        xch_q <= 1'b1;
    end
  end

  always_comb begin
    unique case (reg_addr)
      A_GLOBAL:   reg_rdata = {srst_q, 29'b0, glb_mst, glb_en};
      A_XFER:     reg_rdata = {xch_q, 23'b0, cfg_q};
      A_FIFOCTL:  reg_rdata = {tx_rst_q, 15'b0, rx_rst_q, 15'b0};
      A_FIFOSTAT: reg_rdata = {{(32-CW){1'b0}}, rx_count};
      A_BURST:    reg_rdata = {{(32-CNT_W){1'b0}}, burst_q};
      A_XMIT:     reg_rdata = {{(32-CNT_W){1'b0}}, xmit_q};
      A_TXDATA:   reg_rdata = '0;
      A_RXDATA:   reg_rdata = {24'b0, rx_head};
    endcase
  end

  spi_byte_fifo #(.DW(8), .DEPTH(FIFO_DEPTH)) u_txf (
    .clk(clk), .rst_n(rst_n), .clr(tx_rst_q || srst_q),
    .push(reg_we && reg_addr == A_TXDATA), .wdata(reg_wdata[7:0]),
    .pop(tx_pop), .rdata(tx_head), .count(tx_count),
    .empty(tx_empty), .full(tx_full)
  );

  spi_byte_fifo #(.DW(8), .DEPTH(FIFO_DEPTH)) u_rxf (
    .clk(clk), .rst_n(rst_n), .clr(rx_rst_q || srst_q),
    .push(rx_push), .wdata(rx_wbyte),
    .pop(reg_re && reg_addr == A_RXDATA), .rdata(rx_head), .count(rx_count),
    .empty(rx_empty), .full(rx_full)
  );

  spi_shift_engine #(.CNT_W(CNT_W)) u_eng (
    .clk(clk), .rst_n(rst_n), .clr(srst_q), .start(xch_q),
    .burst_len(burst_q), .xmit_len(xmit_q),
    .cpol(cfg_q[XC_CPOL]), .cpha(cfg_q[XC_CPHA]),
    .tick(sclk_tick), .miso(miso_i),
    .tx_empty(tx_empty), .tx_byte(tx_head), .tx_pop(tx_pop),
    .rx_push(rx_push), .rx_byte(rx_wbyte),
    .sclk(sclk_o), .mosi(mosi_o), .busy(eng_busy), .done(eng_done)
  );

  spi_cs_ctrl #(.NUM_CS(NUM_CS)) u_cs (
    .sel(cfg_q[XC_SEL_LO +: SELW]), .act_low(cfg_q[XC_ACTLOW]),
    .manual(cfg_q[XC_MANUAL]), .man_level(cfg_q[XC_LEVEL]),
    .busy(eng_busy), .cs(cs_o)
  );

endmodule

// File: rtl/spi_burst_master_chk.sv
module spi_burst_master_chk #(
  parameter int FIFO_DEPTH = 64,
  parameter int NUM_CS     = 4,
  parameter int CW         = 7,
  parameter int SELW       = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_we,
  input logic [2:0]        reg_addr,
  input logic [31:0]       reg_wdata,
  input logic              sclk_o,
  input logic [NUM_CS-1:0] cs_o,
  input logic              busy,
  input logic              xch,
  input logic [CW-1:0]     rx_count,
  input logic              en,
  input logic              mst,
  input logic [7:0]        cfg
);

  logic [SELW-1:0] sel;
  assign sel = cfg[4 +: SELW];

  AST_XCH_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (!xch && !(en && mst) && reg_we && reg_addr == 3'd1 && reg_wdata[31]) |=> !xch) // R2
    else $error("exchange bit set while disabled");

  AST_SCLK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (sclk_o == cfg[1])) // R4
    else $error("sclk not at idle level");

  AST_CS_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(cs_o ^ {NUM_CS{cfg[2]}}) <= 1) // R5
    else $error("more than one select active");

  AST_CS_AUTO_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !cfg[6]) |-> (cs_o[sel] == !cfg[2])) // R5
    else $error("selected pin inactive during burst");

  AST_RX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    rx_count <= CW'(FIFO_DEPTH)) // R8
    else $error("rx count beyond depth");

  AST_RX_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == 3'd2 && reg_wdata[15]) |=> ##1 (rx_count == '0)) // R9
    else $error("rx fifo not emptied");

  AST_SRST_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == 3'd0 && reg_wdata[31]) |=> ##1 (!busy && !xch && rx_count == '0)) // R10
    else $error("soft reset did not abort");

endmodule

bind spi_burst_master spi_burst_master_chk #(
  .FIFO_DEPTH(FIFO_DEPTH), .NUM_CS(NUM_CS), .CW(CW), .SELW(SELW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .sclk_o(sclk_o), .cs_o(cs_o), .busy(eng_busy),
  .xch(xch_q), .rx_count(rx_count), .en(glb_en), .mst(glb_mst), .cfg(cfg_q)
);

// File: tb/sim_spi_burst_master.sv
`timescale 1ns/1ps
module sim_spi_burst_master;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0, reg_re = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        sclk_tick = 1'b0;
  logic        sclk_o, mosi_o, miso_i;
  logic [3:0]  cs_o;

  int checks = 0;
  int errors = 0;
  logic [7:0] cur_cfg = '0;
  logic       mon_en = 1'b0;
  logic       prev_sclk = 1'b0;
  logic [7:0] mon_sh = '0;
  int         mon_bits = 0;
  int         mon_n = 0;
  logic [7:0] mon_buf [8];

  always #5 clk = ~clk;
  assign miso_i = mosi_o;

  spi_burst_master u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_re(reg_re),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .sclk_tick(sclk_tick), .sclk_o(sclk_o), .mosi_o(mosi_o),
    .miso_i(miso_i), .cs_o(cs_o)
  );

  initial forever begin
    @(negedge clk);
    sclk_tick = ~sclk_tick;
  end

  // serial monitor: records MOSI on the sampling edge of the active mode
  initial forever begin
    @(negedge clk);
    if (mon_en && sclk_o != prev_sclk) begin
      if (cur_cfg[0] ? (sclk_o == cur_cfg[1]) : (sclk_o != cur_cfg[1])) begin
        mon_sh = {mon_sh[6:0], mosi_o};
        mon_bits++;
        if (mon_bits == 8) begin
          if (mon_n < 8) mon_buf[mon_n] = mon_sh;
          mon_n++;
          mon_bits = 0;
        end
      end
    end
    prev_sclk = sclk_o;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic reg_rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_re = 1'b1; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_re = 1'b0;
  endtask

  task automatic set_cfg(input logic [7:0] c);
    reg_wr(3'd1, {24'b0, c});
    cur_cfg = c;
  endtask

  task automatic start_burst(input int bl, input int xl);
    reg_wr(3'd4, bl);
    reg_wr(3'd5, xl);
    reg_wr(3'd1, {1'b1, 23'b0, cur_cfg});
  endtask

  task automatic wait_done(input string tag);
    logic [31:0] d;
    for (int i = 0; i < 2000; i++) begin
      reg_rd(3'd1, d);
      if (!d[31]) return;
    end
    chk({tag, " burst end"}, 32'd1, 32'd0);
  endtask

  task automatic rx_pop_chk(input string tag, input logic [7:0] exp);
    logic [31:0] d;
    reg_rd(3'd7, d);
    chk(tag, d, {24'b0, exp});
  endtask

  function automatic logic [7:0] pat(input int m, input int i);
    return (8'h96 ^ 8'(i * 53)) + 8'(m * 17);
  endfunction

  task automatic t_reset;
    logic [31:0] d;
    reg_rd(3'd0, d); chk("R1 global", d, 0);
    reg_rd(3'd1, d); chk("R1 xfer", d, 0);
    reg_rd(3'd3, d); chk("R1 rxcount", d, 0);
    chk("R1 cs", {28'b0, cs_o}, 0);
    chk("R1 sclk", {31'b0, sclk_o}, 0);
  endtask

  task automatic t_gate;
    logic [31:0] d;
    reg_wr(3'd6, 32'h11);
    start_burst(1, 1);
    reg_rd(3'd1, d); chk("R2 gated start", {31'b0, d[31]}, 0);
    repeat (60) @(negedge clk);
    reg_rd(3'd3, d); chk("R2 gated no bytes", d, 0);
    reg_wr(3'd0, 32'h3);
    reg_wr(3'd2, 32'h8000_8000);
  endtask

  task automatic t_modes;
    logic [31:0] d;
    for (int m = 0; m < 4; m++) begin
      set_cfg(8'(m));
      chk("R4 sclk idle", {31'b0, sclk_o}, {31'b0, cur_cfg[1]});
      reg_wr(3'd2, 32'h8000_8000);
      for (int i = 0; i < 3; i++) reg_wr(3'd6, {24'b0, pat(m, i)});
      @(negedge clk);
      mon_n = 0; mon_bits = 0; mon_en = 1'b1;
      start_burst(3, 3);
      reg_rd(3'd1, d); chk("R2 busy bit", {31'b0, d[31]}, 1);
      wait_done("R2");
      mon_en = 1'b0;
      chk("R3 mosi count", mon_n, 3);
      for (int i = 0; i < 3; i++) chk("R3 mosi byte", {24'b0, mon_buf[i]}, {24'b0, pat(m, i)});
      reg_rd(3'd3, d); chk("R8 rx count", d, 3);
      for (int i = 0; i < 3; i++) rx_pop_chk("R4 rx byte", pat(m, i));
      reg_rd(3'd3, d); chk("R8 rx drained", d, 0);
    end
  endtask

  task automatic t_xmit;
    set_cfg(8'h00);
    reg_wr(3'd2, 32'h8000_8000);
    reg_wr(3'd6, 32'hA5);
    reg_wr(3'd6, 32'h3C);
    start_burst(3, 1);
    wait_done("R7");
    rx_pop_chk("R7 first from fifo", 8'hA5);
    rx_pop_chk("R7 zero fill", 8'h00);
    rx_pop_chk("R7 zero fill", 8'h00);
    start_burst(2, 2);
    wait_done("R7");
    rx_pop_chk("R7 fifo untouched", 8'h3C);
    rx_pop_chk("R7 empty fifo zero", 8'h00);
  endtask

  task automatic t_cs_auto;
    set_cfg(8'h24);
    chk("R5 idle low-active", {28'b0, cs_o}, 32'hF);
    start_burst(2, 0);
    repeat (12) @(negedge clk);
    chk("R5 busy low-active", {28'b0, cs_o}, 32'hB);
    wait_done("R5");
    chk("R5 released", {28'b0, cs_o}, 32'hF);
    set_cfg(8'h10);
    chk("R5 idle high-active", {28'b0, cs_o}, 32'h0);
    start_burst(2, 0);
    repeat (12) @(negedge clk);
    chk("R5 busy high-active", {28'b0, cs_o}, 32'h2);
    wait_done("R5");
    reg_wr(3'd2, 32'h0000_8000);
  endtask

  task automatic t_cs_man;
    set_cfg(8'h74);
    chk("R6 manual asserted", {28'b0, cs_o}, 32'h7);
    start_burst(1, 0);
    wait_done("R6");
    chk("R6 held after burst", {28'b0, cs_o}, 32'h7);
    start_burst(1, 0);
    wait_done("R6");
    chk("R6 held after second burst", {28'b0, cs_o}, 32'h7);
    set_cfg(8'hF4);
    chk("R6 manual released", {28'b0, cs_o}, 32'hF);
    set_cfg(8'h00);
    reg_wr(3'd2, 32'h0000_8000);
  endtask

  task automatic t_zero;
    logic [31:0] d;
    start_burst(0, 0);
    reg_rd(3'd1, d); chk("R11 cleared", {31'b0, d[31]}, 0);
    reg_rd(3'd3, d); chk("R11 no bytes", d, 0);
  endtask

  task automatic t_fifo_rst;
    logic [31:0] d;
    start_burst(2, 0);
    wait_done("R9");
    reg_rd(3'd3, d); chk("R9 pre count", d, 2);
    reg_wr(3'd2, 32'h0000_8000);
    reg_rd(3'd3, d); chk("R9 rx emptied", d, 0);
    reg_rd(3'd2, d); chk("R9 self clear", d, 0);
    reg_wr(3'd6, 32'h77);
    reg_wr(3'd6, 32'h88);
    reg_wr(3'd2, 32'h8000_0000);
    start_burst(1, 1);
    wait_done("R9");
    rx_pop_chk("R9 tx emptied", 8'h00);
  endtask

  task automatic t_srst;
    logic [31:0] d;
    set_cfg(8'h02);
    for (int i = 0; i < 4; i++) reg_wr(3'd6, 32'h5A);
    start_burst(4, 4);
    repeat (50) @(negedge clk);
    reg_wr(3'd0, 32'h8000_0003);
    reg_rd(3'd1, d); chk("R10 exchange cleared", {31'b0, d[31]}, 0);
    reg_rd(3'd3, d); chk("R10 rx emptied", d, 0);
    reg_rd(3'd0, d); chk("R10 global kept", d, 3);
    chk("R10 sclk idle", {31'b0, sclk_o}, 1);
    start_burst(1, 1);
    wait_done("R10");
    rx_pop_chk("R10 tx emptied", 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_gate();
    t_modes();
    t_xmit();
    t_cs_auto();
    t_cs_man();
    t_zero();
    t_fifo_rst();
    t_srst();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule